// File: doc/BRIEF.md
# Transmit Command-Word Parser

This block sits behind the 32-bit transmit data port of a network controller. Software writes a stream of words into a small word FIFO. Each buffer in that stream starts with two command words. The first gives the byte count, a starting byte offset, an end-alignment mode and three control bits: first segment, last segment and interrupt on completion. The second carries a 16-bit frame tag in its upper half.

The parser walks the stream word by word. It drops whole words that lie inside the offset and skips the leading lanes of the first data word. It unpacks payload bytes least significant byte first onto a valid/ready byte stream. Alignment pad words are discarded. When a buffer completes with the last-segment bit set, the block pulses a frame-sent output and queues the tag into a small status FIFO.

Three sticky flags report these events: completion interrupt, write overflow and status FIFO full. A dump request throws away queued words and returns the parser to waiting for a first command word. The block also reports the free space in the word FIFO.

Top module: `tx_word_parser`

## Requirements
- R1: After reset, `byte_valid` and `stat_valid` are 0, `flags` is 0 and `free_words` equals DEPTH.
- R2: First command word fields are size in bits 10:0, offset in bits 20:16, alignment mode in bits 25:24, last segment in bit 12, first segment in bit 13 and completion interrupt in bit 31. The second command word's bits 31:16 are the tag.
- R3: Data words wholly inside the offset are discarded. In the next data word, lanes below offset mod 4 are skipped. Exactly `size` bytes are emitted, lane 0 (bits 7:0) first, continuing into later words.
- R4: Alignment mode 1 adds pad words until the data-word count (ceil((size+offset)/4)) is a multiple of 4. Mode 2 pads to a multiple of 8, and modes 0 and 3 add none. Pad words are consumed and produce no bytes.
- R5: When no bytes and no pad remain, the buffer completes and the parser expects a new first command word. If the last-segment bit is set, `frame_sent` pulses for one cycle and the tag is queued into the status FIFO, read via `stat_valid`/`stat_tag`/`stat_pop`.
- R6: A completing buffer whose completion-interrupt bit is set sets `flags[0]`.
- R7: A command pair without the first-segment bit reloads neither size, offset, pad nor tag. With nothing left from the previous buffer, it completes at once without consuming data words, and a queued tag is the earlier one.
- R8: A write while the word FIFO holds DEPTH words is dropped and sets `flags[1]`.
- R9: A tag push that fills the status FIFO to SDEPTH entries sets `flags[2]`. Tags pushed while it is full are dropped.
- R10: `dump` empties the word FIFO and returns the parser to waiting for a first command word, ending any byte in progress.
- R11: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` holds its value.
- R12: `free_words` equals DEPTH minus the number of words held in the word FIFO.
- R13: A 1 in `flag_clr` clears the matching bit of `flags`. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one word into the word FIFO |
| wr_data | input | 32 | Word written |
| dump | input | 1 | Discard queued words, parser to idle |
| free_words | output | $clog2(DEPTH+1) | Free word slots |
| byte_valid | output | 1 | Payload byte available |
| byte_data | output | 8 | Payload byte |
| byte_ready | input | 1 | Consumer accepts the byte |
| frame_sent | output | 1 | One-cycle pulse per completed last segment |
| stat_valid | output | 1 | Status FIFO not empty |
| stat_tag | output | 16 | Tag at status FIFO head |
| stat_pop | input | 1 | Remove status head |
| flag_clr | input | 3 | Clear mask for flags |
| flags | output | 3 | bit0 completion, bit1 overflow, bit2 status full |

## Verification
The assertions assume that `dump` is not asserted in the same cycle as a handshake they reason about. They also assume that `byte_ready` is driven from a register-stable source, so that a stalled byte sees the same ready value for a whole cycle. The stimulus changes every input only at the falling clock edge and pulses `dump` only while the consumer is stalled. Words are written only when `free_words` is nonzero, except for the single deliberate overflow write, so every other word enters the FIFO as the reference model expects.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [1:0] {PS_CMDA, PS_CMDB, PS_DATA, PS_EMIT} pstate_e;

  localparam int SZ_W  = 11;
  localparam int OFF_W = 5;
  localparam int PAD_W = 3;
  localparam int TAG_W = 16;

  typedef struct packed {
    logic             ioc;
    logic [1:0]       pmode;
    logic [OFF_W-1:0] off;
    logic             first;
    logic             last;
    logic [SZ_W-1:0]  size;
  } cmda_t;

  function automatic cmda_t decode_cmda(input logic [31:0] w);
    cmda_t c;
    c.ioc   = w[31];
    c.pmode = w[25:24];
    c.off   = w[20:16];
    c.first = w[13];
    c.last  = w[12];
    c.size  = w[10:0];
    return c;
  endfunction

  // Pad words needed so the data-word count meets the alignment mode.
  function automatic logic [PAD_W-1:0] pad_words(input logic [SZ_W-1:0] size,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [1:0] mode);
    logic [12:0] nw;
    logic [12:0] neg;
    nw  = ({2'b00, size} + {8'd0, off} + 13'd3) >> 2;
    neg = 13'd0 - nw;
    case (mode)
      2'd1:    return neg[2:0] & 3'b011;
      2'd2:    return neg[2:0];
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/txw_fifo.sv
module txw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH)) && !clr;
  assign do_pop  = pop && (cnt_q != '0) && !clr;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

  // R12: occupancy never exceeds capacity
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/txw_parser.sv
module txw_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dump,
  input  logic        word_valid,
  input  logic [31:0] word_data,
  output logic        word_pop,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  input  logic        byte_ready,
  output logic        fin,
  output logic        fin_last,
  output logic        fin_ioc,
  output logic [15:0] fin_tag
);
  import txw_pkg::*;

  pstate_e          st_q, st_d;
  cmda_t            ca_q, ca_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [SZ_W-1:0]  size_q, size_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PAD_W-1:0] pad_q, pad_d;
  logic [31:0]      hold_q, hold_d;
  logic [1:0]       idx_q, idx_d;

  always_comb begin
    st_d     = st_q;
    ca_d     = ca_q;
    tag_d    = tag_q;
    size_d   = size_q;
    off_d    = off_q;
    pad_d    = pad_q;
    hold_d   = hold_q;
    idx_d    = idx_q;
    word_pop = 1'b0;
    fin      = 1'b0;
    case (st_q)
      PS_CMDA: if (word_valid) begin
        word_pop = 1'b1;
        ca_d     = decode_cmda(word_data);
        st_d     = PS_CMDB;
      end
      PS_CMDB: if (word_valid) begin
        word_pop = 1'b1;
        if (ca_q.first) begin
          tag_d  = word_data[31:16];
          size_d = ca_q.size;
          off_d  = ca_q.off;
          pad_d  = pad_words(ca_q.size, ca_q.off, ca_q.pmode);
        end
        st_d = PS_DATA;
      end
      PS_DATA: begin
        if (size_q == '0 && pad_q == '0) begin
          fin  = 1'b1;
          st_d = PS_CMDA;
        end else if (word_valid) begin
          word_pop = 1'b1;
          if (off_q >= OFF_W'(4)) begin
            off_d = off_q - OFF_W'(4);
          end else if (size_q == '0) begin
            pad_d = pad_q - 1'b1;
          end else begin
            hold_d = word_data;
            idx_d  = off_q[1:0];
            off_d  = '0;
            st_d   = PS_EMIT;
          end
        end
      end
      default: if (byte_ready) begin
        size_d = size_q - 1'b1;
        idx_d  = idx_q + 1'b1;
        if (idx_q == 2'd3 || size_q == SZ_W'(1)) st_d = PS_DATA;
      end
    endcase
    if (dump) begin
      st_d     = PS_CMDA;
      ca_d     = '1;
      word_pop = 1'b0;
      fin      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_CMDA;
      ca_q   <= '1;
      tag_q  <= '0;
      size_q <= '0;
      off_q  <= '0;
      pad_q  <= '0;
      hold_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      ca_q   <= ca_d;
      tag_q  <= tag_d;
      size_q <= size_d;
      off_q  <= off_d;
      pad_q  <= pad_d;
      hold_q <= hold_d;
      idx_q  <= idx_d;
    end
  end

  always_comb begin
    case (idx_q)
      2'd0:    byte_data = hold_q[7:0];
      2'd1:    byte_data = hold_q[15:8];
      2'd2:    byte_data = hold_q[23:16];
      default: byte_data = hold_q[31:24];
    endcase
  end

  assign byte_valid = (st_q == PS_EMIT);
  assign fin_last   = ca_q.last;
  assign fin_ioc    = ca_q.ioc;
  assign fin_tag    = tag_q;

  // R11: a stalled byte is held
  p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready && !dump |=> byte_valid && $stable(byte_data));
  // R10: dump ends any byte in progress
  p_dump_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> !byte_valid);
  // R5: completion returns to command parsing, never straight to output
  p_fin_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !byte_valid);
endmodule

// File: rtl/tx_word_parser.sv
module tx_word_parser #(
  parameter int DEPTH  = 16,
  parameter int SDEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [31:0]                 wr_data,
  input  logic                        dump,
  output logic [$clog2(DEPTH+1)-1:0]  free_words,
  output logic                        byte_valid,
  output logic [7:0]                  byte_data,
  input  logic                        byte_ready,
  output logic                        frame_sent,
  output logic                        stat_valid,
  output logic [15:0]                 stat_tag,
  input  logic                        stat_pop,
  input  logic [2:0]                  flag_clr,
  output logic [2:0]                  flags
);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int SCW = $clog2(SDEPTH+1);

  logic [1:0]     rs_q;
  logic           rst_q;
  logic [31:0]    wword;
  logic [CW-1:0]  wcount;
  logic [SCW-1:0] scount;
  logic           wpop, fin, fin_last, fin_ioc;
  logic [15:0]    fin_tag;
  logic           spush;
  logic [2:0]     flags_q, flags_d, fset;
  logic           sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  txw_fifo #(.W(32), .DEPTH(DEPTH)) u_words (
    .clk(clk), .rst_n(rst_q), .clr(dump), .push(wr_en), .din(wr_data),
    .pop(wpop), .dout(wword), .count(wcount));

  txw_parser u_parse (
    .clk(clk), .rst_n(rst_q), .dump(dump),
    .word_valid(wcount != '0), .word_data(wword), .word_pop(wpop),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .fin(fin), .fin_last(fin_last), .fin_ioc(fin_ioc), .fin_tag(fin_tag));

  assign spush = fin && fin_last;

  txw_fifo #(.W(16), .DEPTH(SDEPTH)) u_stat (
    .clk(clk), .rst_n(rst_q), .clr(1'b0), .push(spush), .din(fin_tag),
    .pop(stat_pop), .dout(stat_tag), .count(scount));

  always_comb begin
    fset[0] = fin && fin_ioc;
    fset[1] = wr_en && (wcount == CW'(DEPTH)) && !dump;
    fset[2] = spush && (scount == SCW'(SDEPTH-1)) && !stat_pop;
    flags_d = (flags_q & ~flag_clr) | fset;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      flags_q <= '0;
      sent_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      sent_q  <= spush;
    end
  end

  assign flags      = flags_q;
  assign frame_sent = sent_q;
  assign stat_valid = (scount != '0);
  assign free_words = CW'(DEPTH) - wcount;

  // R8: a write into a full FIFO raises the overflow flag
  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en && (free_words == '0) && !dump |=> flags[1]);
  // R9: a full status FIFO is reported
  p_stat_full_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (scount == SCW'(SDEPTH)) && $changed(scount) |-> flags[2]);
endmodule

// File: tb/test_tx_word_parser.sv
module test_tx_word_parser;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int SDEPTH = 4;
  localparam int CW     = $clog2(DEPTH+1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        dump = 1'b0;
  logic [CW-1:0] free_words;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready = 1'b0;
  logic        frame_sent;
  logic        stat_valid;
  logic [15:0] stat_tag;
  logic        stat_pop = 1'b0;
  logic [2:0]  flag_clr = '0;
  logic [2:0]  flags;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int got_sent = 0;
  int exp_sent = 0;
  bit stall = 1'b0;
  bit ready_pat = 1'b0;
  bit done = 1'b0;
  logic [7:0]  exp_bytes[$];
  logic [15:0] exp_tags[$];

  always #(PERIOD/2) clk = ~clk;

  tx_word_parser #(.DEPTH(DEPTH), .SDEPTH(SDEPTH)) i_tx_word_parser (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .dump(dump),
    .free_words(free_words), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .frame_sent(frame_sent), .stat_valid(stat_valid),
    .stat_tag(stat_tag), .stat_pop(stat_pop), .flag_clr(flag_clr), .flags(flags));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference byte stream compared on every clock
  always @(negedge clk) begin
    cyc++;
    byte_ready = stall ? 1'b0 : (ready_pat ? (cyc % 3 != 0) : 1'b1);
    #1;
    if (frame_sent) got_sent++;
    if (byte_valid && byte_ready) begin
      if (exp_bytes.size() == 0) chk(1'b0, "R3 unexpected byte", byte_data, 0);
      else begin
        logic [7:0] e;
        e = exp_bytes.pop_front();
        chk(byte_data == e, "R3 byte order", byte_data, e);
      end
    end
  end

  task automatic put(input logic [31:0] w);
    while (free_words == '0) @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cmd_a(bit first, bit last, bit ioc, int size, int off, int pm);
    return {ioc, 5'b0, 2'(pm), 3'b0, 5'(off), 2'b0, first, last, 1'b0, 11'(size)};
  endfunction

  // R2 field layout; R4 pad rule computed here from the requirement
  task automatic send_buf(bit first, bit last, bit ioc, int size, int off, int pm,
                          logic [15:0] tag, logic [7:0] base);
    put(cmd_a(first, last, ioc, size, off, pm));
    put({tag, 16'hA5A5});
    if (first) begin
      int nw, pad;
      nw = (size + off + 3) / 4;
      pad = (pm == 1) ? (4 - nw % 4) % 4 : (pm == 2) ? (8 - nw % 8) % 8 : 0;
      for (int k = 0; k < size; k++) exp_bytes.push_back(8'(base + off + k));
      for (int w = 0; w < nw; w++)
        put({8'(base + 4*w + 3), 8'(base + 4*w + 2), 8'(base + 4*w + 1), 8'(base + 4*w)});
      for (int p = 0; p < pad; p++) put(32'hDEADBEEF);
    end
    if (last) begin
      exp_tags.push_back(tag);
      exp_sent++;
    end
  endtask

  task automatic drain(input string req);
    while (exp_bytes.size() != 0 || free_words != CW'(DEPTH)) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(got_sent == exp_sent, {req, " frame_sent count"}, got_sent, exp_sent);
    chk(free_words == CW'(DEPTH), {req, " R12 free after drain"}, free_words, DEPTH);
  endtask

  task automatic pop_tags(input string req);
    while (exp_tags.size() != 0) begin
      logic [15:0] e;
      e = exp_tags.pop_front();
      chk(stat_valid && stat_tag == e, {req, " status tag"}, stat_tag, e);
      stat_pop = 1'b1;
      @(negedge clk);
      stat_pop = 1'b0;
    end
    chk(!stat_valid, {req, " status empty"}, stat_valid, 0);
  endtask

  task automatic clear_flags(input logic [2:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!byte_valid, "R1 byte_valid", byte_valid, 0);
    chk(!stat_valid, "R1 stat_valid", stat_valid, 0);
    chk(flags == 3'b000, "R1 flags", flags, 0);
    chk(free_words == CW'(DEPTH), "R1 R12 free_words", free_words, DEPTH);

    // R2 R3 R5 plain buffer
    send_buf(1, 1, 0, 8, 0, 0, 16'h1234, 8'h10);
    drain("R5 plain");
    pop_tags("R5 plain");

    // R3 lane offset and whole-word offset, R11 with stalling consumer
    ready_pat = 1'b1;
    send_buf(1, 1, 0, 5, 2, 0, 16'h2222, 8'h40);
    send_buf(1, 1, 0, 10, 7, 0, 16'h3333, 8'h80);
    drain("R3 offset");
    pop_tags("R3 offset");
    ready_pat = 1'b0;

    // R4 alignment pad words
    send_buf(1, 1, 0, 4, 0, 1, 16'h4444, 8'h20);
    send_buf(1, 1, 0, 9, 1, 2, 16'h5555, 8'h60);
    send_buf(1, 1, 0, 6, 0, 3, 16'h5A5A, 8'h30);
    drain("R4 pad");
    pop_tags("R4 pad");
    chk(flags == 3'b000, "R4 no flags", flags, 0);

    // R6 completion interrupt, R13 clear
    send_buf(1, 1, 1, 3, 0, 0, 16'h6666, 8'h00);
    drain("R6 ioc");
    chk(flags[0], "R6 ioc flag", flags[0], 1);
    clear_flags(3'b001);
    chk(!flags[0], "R13 ioc clear", flags[0], 0);
    pop_tags("R6 ioc");

    // R7 continuation segment reloads nothing
    send_buf(1, 0, 0, 3, 0, 0, 16'h0BAD, 8'h70);
    send_buf(0, 1, 0, 3, 0, 0, 16'hFFFF, 8'h00);
    exp_tags[exp_tags.size()-1] = 16'h0BAD;
    drain("R7 segment");
    pop_tags("R7 segment");

    // R9 status full and dropped tags
    for (int i = 0; i < SDEPTH; i++) send_buf(1, 1, 0, 1, 0, 0, 16'h7000 + 16'(i), 8'h01);
    drain("R9 fill");
    chk(flags[2], "R9 status full flag", flags[2], 1);
    send_buf(1, 1, 0, 1, 0, 0, 16'h7FFF, 8'h02);
    void'(exp_tags.pop_back());
    drain("R9 drop");
    pop_tags("R9 drop");
    clear_flags(3'b100);
    chk(!flags[2], "R13 sfull clear", flags[2], 0);

    // R8 overflow, R11 hold, R10 dump
    stall = 1'b1;
    put(cmd_a(1, 1, 0, 40, 0, 0));
    put(32'h9999_0000);
    put(32'h44332211);
    repeat (10) @(negedge clk);
    chk(free_words == CW'(DEPTH), "R12 parsed words released", free_words, DEPTH);
    chk(byte_valid && byte_data == 8'h11, "R11 held byte", byte_data, 8'h11);
    for (int i = 0; i < DEPTH; i++) put(32'(i));
    chk(free_words == '0, "R12 full", free_words, 0);
    wr_en = 1'b1;
    wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk(flags[1], "R8 overflow flag", flags[1], 1);
    chk(free_words == '0, "R8 dropped write", free_words, 0);
    chk(byte_valid && byte_data == 8'h11, "R11 still held", byte_data, 8'h11);
    dump = 1'b1;
    @(negedge clk);
    dump = 1'b0;
    chk(free_words == CW'(DEPTH), "R10 dump empties", free_words, DEPTH);
    chk(!byte_valid, "R10 dump ends byte", byte_valid, 0);
    stall = 1'b0;
    clear_flags(3'b010);
    chk(!flags[1], "R13 ovf clear", flags[1], 0);
    send_buf(1, 1, 0, 6, 3, 0, 16'hABCD, 8'hC0);
    drain("R10 resume");
    pop_tags("R10 resume");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule